// File: doc/BRIEF.md
# Chunked Split-Tree Mantissa Multiplier

This block forms the full 104-bit unsigned product of two 52-bit mantissas without a wide multiplier or a wide adder. Each operand is cut into four 13-bit chunks that are held in chunk registers. Sixteen 13×13 multiplier cells form every pairing of an A chunk with a B chunk, so each chunk feeds four cells. The 26-bit product of A chunk i and B chunk j carries a weight of 2^(13·(i+j)). In the 104-bit frame it is cut at bit 52 into a lower piece and an upper piece, and only the pieces that are not empty are kept.

The ten lower pieces are reduced by one pipelined four-level adder tree and the ten upper pieces by a second, identical tree. A final merge stage adds the upper sum, weighted by 2^52, to the lower sum. Any bits of the lower sum above bit 51 fall into the upper half at that point. The block takes a new operand pair on every cycle. A valid flag travels alongside the data through all seven register stages.

Top module: `split_tree_multiplier`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `outValid` is 0 and `product` is 0.
- R2: For any operands, the `product` that goes out with `outValid` equals opA × opB as an unsigned 104-bit value.
- R3: `outValid` is 1 exactly seven clock cycles after a cycle in which `inValid` was sampled high, and is 0 otherwise.
- R4: Operand pairs presented on consecutive cycles give results on consecutive cycles, in the same order, with no bubble.
- R5: While `outValid` is 0, `product` keeps the last delivered result, and operand values presented with `inValid` low have no effect on it.
- R6: All-ones operands (2^52−1 each) give (2^52−1)², the case where carries from the lower tree run into the upper half.
- R7: When A has only chunk i nonzero and B has only chunk j nonzero, the product is their chunk product placed at bit 13·(i+j). Chunk k is operand bits [13k+12:13k], for every i, j in 0..3.
- R8: If either operand is zero, the product is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand pair on opA/opB is valid this cycle |
| opA | input | 52 | First unsigned mantissa |
| opB | input | 52 | Second unsigned mantissa |
| outValid | output | 1 | product holds a new result this cycle |
| product | output | 104 | Full unsigned product |

## Verification
The hardest case to reach from the ports is a lower-tree sum that overflows past bit 51 while the upper tree is also carrying, because the merge must then propagate that carry correctly across the split line. Random operands seldom stress this. The stimulus therefore drives all-ones operands and operands whose chunks are near full scale. It also sweeps all sixteen single-chunk pairings, which places each cell's product alone in the lower tree, alone in the upper tree, or straddling both. Random pairs are sent back to back and then with gaps, and junk operands are driven during the gaps, to show that the pipeline neither drops, reorders nor picks up data.

// File: rtl/smul_pkg.sv
package smul_pkg;
  localparam int CHUNK_W  = 13;
  localparam int N_CHUNK  = 4;
  localparam int OP_W     = CHUNK_W * N_CHUNK;
  localparam int PROD_W   = 2 * OP_W;
  localparam int HALF_W   = OP_W;
  localparam int CPROD_W  = 2 * CHUNK_W;

  // highest chunk weight index (i+j) whose product still has a bit below the split
  localparam int LO_MAX_K = (HALF_W - 1) / CHUNK_W;
  // lowest chunk weight index whose product reaches across the split
  localparam int HI_MIN_K = (HALF_W - CPROD_W + CHUNK_W) / CHUNK_W;

  function automatic int countPieces(input bit upperSide);
    int n;
    n = 0;
    for (int i = 0; i < N_CHUNK; i++)
      for (int j = 0; j < N_CHUNK; j++)
        if (upperSide ? (i + j >= HI_MIN_K) : (i + j <= LO_MAX_K)) n++;
    return n;
  endfunction

  localparam int N_LO        = countPieces(1'b0);
  localparam int N_HI        = countPieces(1'b1);
  localparam int N_MAX       = (N_LO > N_HI) ? N_LO : N_HI;
  localparam int TREE_LEVELS = $clog2(N_MAX);
  localparam int TREE_W      = HALF_W + TREE_LEVELS;
  // operand regs, chunk products, tree levels, merge
  localparam int LATENCY     = 2 + TREE_LEVELS + 1;

  typedef struct packed {
    logic                   ldOperand;
    logic                   ldProduct;
    logic [TREE_LEVELS-1:0] treeEn;
    logic                   ldMerge;
  } strobes_t;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output strobes_t strobes,
  output logic     outValid
);
  logic [LATENCY:1] vld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vld <= '0;
    else       vld <= {vld[LATENCY-1:1], inValid};
  end

  always_comb begin
    strobes.ldOperand = inValid;
    strobes.ldProduct = vld[1];
    for (int l = 0; l < TREE_LEVELS; l++) strobes.treeEn[l] = vld[2 + l];
    strobes.ldMerge   = vld[2 + TREE_LEVELS];
  end

  assign outValid = vld[LATENCY];
endmodule

// File: rtl/smul_tree.sv
module smul_tree #(
  parameter int W      = 56,
  parameter int N_IN   = 10,
  parameter int LEVELS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEVELS-1:0] stgEn,
  input  logic [W-1:0]      din [N_IN],
  output logic [W-1:0]      sum
);
  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int PREV = (N_IN + (1 << (l - 1)) - 1) >> (l - 1);
    localparam int CUR  = (N_IN + (1 << l) - 1) >> l;
    logic [W-1:0] src  [PREV];
    logic [W-1:0] node [CUR];

    if (l == 1) begin : g_first
      always_comb src = din;
    end else begin : g_rest
      always_comb src = g_lvl[l-1].node;
    end

    for (genvar k = 0; k < CUR; k++) begin : g_node
      if (2 * k + 1 < PREV) begin : g_add
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)              node[k] <= '0;
          else if (stgEn[l - 1])  node[k] <= src[2 * k] + src[2 * k + 1];
        end
      end else begin : g_pass
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)              node[k] <= '0;
          else if (stgEn[l - 1])  node[k] <= src[2 * k];
        end
      end
    end
  end

  assign sum = g_lvl[LEVELS].node[0];
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath
  import smul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [PROD_W-1:0] product
);
  logic [CHUNK_W-1:0] aChunk [N_CHUNK];
  logic [CHUNK_W-1:0] bChunk [N_CHUNK];
  logic [CPROD_W-1:0] cellProd [N_CHUNK][N_CHUNK];
  logic [TREE_W-1:0]  loIn [N_LO];
  logic [TREE_W-1:0]  hiIn [N_HI];
  logic [TREE_W-1:0]  loSum;
  logic [TREE_W-1:0]  hiSum;

  // chunk registers: each chunk is held once per operand and fanned out to four cells
  for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aChunk[c] <= '0;
        bChunk[c] <= '0;
      end else if (strobes.ldOperand) begin
        aChunk[c] <= opA[c*CHUNK_W +: CHUNK_W];
        bChunk[c] <= opB[c*CHUNK_W +: CHUNK_W];
      end
    end
  end

  // sixteen chunk-product cells
  for (genvar i = 0; i < N_CHUNK; i++) begin : g_row
    for (genvar j = 0; j < N_CHUNK; j++) begin : g_cell
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  cellProd[i][j] <= '0;
        else if (strobes.ldProduct) cellProd[i][j] <= aChunk[i] * bChunk[j];
      end
    end
  end

  // place each cell product at its weight and cut it at the split line
  always_comb begin
    int loCnt;
    int hiCnt;
    logic [PROD_W-1:0] placed;
    loCnt = 0;
    hiCnt = 0;
    for (int n = 0; n < N_LO; n++) loIn[n] = '0;
    for (int n = 0; n < N_HI; n++) hiIn[n] = '0;
    for (int i = 0; i < N_CHUNK; i++) begin
      for (int j = 0; j < N_CHUNK; j++) begin
        placed = PROD_W'(cellProd[i][j]) << (CHUNK_W * (i + j));
        if (i + j <= LO_MAX_K) begin
          loIn[loCnt] = TREE_W'(placed[HALF_W-1:0]);
          loCnt++;
        end
        if (i + j >= HI_MIN_K) begin
          hiIn[hiCnt] = TREE_W'(placed[PROD_W-1:HALF_W]);
          hiCnt++;
        end
      end
    end
  end

  smul_tree #(.W(TREE_W), .N_IN(N_LO), .LEVELS(TREE_LEVELS)) u_loTree (
    .clk(clk), .rstN(rstN), .stgEn(strobes.treeEn), .din(loIn), .sum(loSum)
  );

  smul_tree #(.W(TREE_W), .N_IN(N_HI), .LEVELS(TREE_LEVELS)) u_hiTree (
    .clk(clk), .rstN(rstN), .stgEn(strobes.treeEn), .din(hiIn), .sum(hiSum)
  );

  // merge: upper sum weighted at the split, lower-sum overflow carries into it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                product <= '0;
    else if (strobes.ldMerge) product <= (PROD_W'(hiSum) << HALF_W) + PROD_W'(loSum);
  end
endmodule

// File: rtl/split_tree_multiplier.sv
module split_tree_multiplier
  import smul_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic              outValid,
  output logic [PROD_W-1:0] product
);
  strobes_t strobes;

  smul_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobes(strobes), .outValid(outValid)
  );

  smul_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opA(opA), .opB(opB), .product(product)
  );
endmodule

// File: rtl/smul_checker.sv
module smul_checker
  import smul_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   opA,
  input logic [OP_W-1:0]   opB,
  input logic              outValid,
  input logic [PROD_W-1:0] product
);
  logic [LATENCY-1:0] vldHist;
  logic [LATENCY-1:0] zeroHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vldHist  <= '0;
      zeroHist <= '0;
    end else begin
      vldHist  <= {vldHist[LATENCY-2:0], inValid};
      zeroHist <= {zeroHist[LATENCY-2:0], inValid && (opA == '0 || opB == '0)};
    end
  end

  // R1
  always_comb begin
    if (!rstN) begin
      reset_quiet_chk: assert (!outValid && product == '0);
    end
  end

  // R3
  latency_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == vldHist[LATENCY-1]);

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(product));

  // R8
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && zeroHist[LATENCY-1]) |-> product == '0);
endmodule

bind split_tree_multiplier smul_checker u_smulChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .outValid(outValid), .product(product)
);

// File: tb/split_tree_multiplier_bench.sv
`timescale 1ns/1ps
module split_tree_multiplier_bench;
  localparam int OPW = 52;
  localparam int PW  = 104;
  localparam int LAT = 7;

  typedef struct {
    bit          v;
    logic [PW-1:0] p;
    string       tag;
  } expEntry_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [OPW-1:0] opA = '0;
  logic [OPW-1:0] opB = '0;
  logic          outValid;
  logic [PW-1:0] product;

  int errors = 0;
  int checks = 0;
  bit seenResult = 0;
  logic [PW-1:0] lastResult = '0;
  expEntry_t pipeQ[$];

  always #5 clk = ~clk;

  split_tree_multiplier u_split_tree_multiplier (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .product(product)
  );

  function automatic logic [OPW-1:0] rnd52();
    return OPW'({$urandom(), $urandom()});
  endfunction

  task automatic checkOne(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare outputs against the entry driven LAT cycles earlier, then drive a new one
  task automatic step(input bit v, input logic [OPW-1:0] a, input logic [OPW-1:0] b, input string tag);
    expEntry_t e;
    @(negedge clk);
    if (pipeQ.size() == LAT) begin
      e = pipeQ.pop_front();
      checkOne("R3 outValid", PW'(outValid), PW'(e.v));
      if (e.v) begin
        checkOne(e.tag, product, e.p);
        lastResult = e.p;
        seenResult = 1;
      end else if (seenResult) begin
        checkOne("R5 hold", product, lastResult);
      end
    end
    inValid = v;
    opA = a;
    opB = b;
    e.v = v;
    e.p = PW'(a) * PW'(b);
    e.tag = tag;
    pipeQ.push_back(e);
  endtask

  initial begin
    repeat (LAT * 2000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      checkOne("R1 reset outValid", PW'(outValid), '0);
      checkOne("R1 reset product", product, '0);
    end
    rstN = 1'b1;
    @(negedge clk);
    checkOne("R1 after release outValid", PW'(outValid), '0);
    checkOne("R1 after release product", product, '0);

    // R8: zero operands
    step(1, '0, rnd52(), "R8 zero A");
    step(1, rnd52(), '0, "R8 zero B");
    step(1, '0, '0, "R8 both zero");

    // R6: all-ones and near-full chunks, carry across the split
    step(1, '1, '1, "R6 all ones");
    step(1, '1, 52'h1, "R6 ones times one");
    step(1, {4{13'h1FFF}} ^ 52'h1, '1, "R6 near full");
    step(1, {4{13'h1FFE}}, {4{13'h1FFF}}, "R6 chunk full");

    // R7: each single-chunk pairing
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [12:0] ca;
        logic [12:0] cb;
        ca = 13'($urandom()) | 13'h1000;
        cb = (i == j) ? 13'h1FFF : (13'($urandom()) | 13'h1);
        step(1, OPW'(ca) << (13 * i), OPW'(cb) << (13 * j), $sformatf("R7 chunk %0d x %0d", i, j));
      end
    end

    // R2 / R4: random pairs back to back
    for (int n = 0; n < 60; n++) step(1, rnd52(), rnd52(), "R4 back-to-back R2");

    // R5 / R3: gaps with junk operands presented while invalid
    for (int n = 0; n < 60; n++) begin
      if ($urandom_range(0, 2) == 0) step(1, rnd52(), rnd52(), "R2 random gapped");
      else                           step(0, rnd52(), rnd52(), "R5 idle junk");
    end

    // R3: isolated pulse
    step(1, rnd52(), rnd52(), "R3 isolated pulse R2");
    for (int n = 0; n < LAT + 3; n++) step(0, rnd52(), rnd52(), "R5 drain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule